// File: doc/BRIEF.md
# PIPE Receiver Detection Sequencer

This block sits on the PHY side of a PIPE-style link and answers the MAC's request to probe for a far-end receiver. The MAC raises the detect request while the lane is in the P1 power state. The block then runs a timed detection window of a fixed number of clocks. At the end of that window it takes one sample of a digital "receiver present" flag, which comes from an abstracted analog comparator. It returns the result as a single-clock done pulse together with a 3-bit status code.

Only a rising edge of the request can start a window, and only while the powerdown field holds P1. A request in any other power state is not acted on. A request that stays high does not trigger a second window. The status bus is zero at every moment except the done cycle, so the MAC can sample status on done without any extra qualification.

Top module: `rxdet_seq`

## Requirements
- R1: A synchronous, active-high reset drives done low and status to 3'b000 on the next clock. It abandons any window in progress, and a request that is held high through reset does not start a window afterwards.
- R2: A detection window starts only if the request rises while the powerdown input equals 2'b10 (P1). A rising request under 2'b00, 2'b01 or 2'b11 never produces a done pulse, and status stays 3'b000.
- R3: Call the first rising clock edge that sees the request high the capture edge. Done goes high exactly DETECT_CYCLES clock edges after the capture edge, and stays low before then.
- R4: Done is high for exactly one clock cycle per window.
- R5: If the comparator input is 1 at the clock edge that raises done, status reads 3'b011 during the done cycle.
- R6: If the comparator input is 0 at the clock edge that raises done, status reads 3'b000 during the done cycle.
- R7: Status is 3'b000 whenever done is low, including the cycle right after the done pulse.
- R8: Each rising edge of the request starts at most one window. Holding the request high, or making it rise again while a window is running, starts no further window.
- R9: The comparator is sampled only at the edge that raises done. Its value earlier in the window has no effect on the reported status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| detReq | input | 1 | Receiver-detect request from the MAC |
| pwrState | input | 2 | Powerdown field; 2'b10 selects P1 |
| farEndSeen | input | 1 | Comparator flag: far-end receiver present |
| phyDone | output | 1 | One-cycle completion pulse |
| phyStatus | output | 3 | Outcome code: 3'b011 found, 3'b000 otherwise |

## Verification
The in-line assertions check, on every cycle, the following:
- done is one cycle wide;
- status is zero outside done and holds one of the two legal codes during done;
- a window only begins after a P1 request;
- done follows the last count of the window.

Only the bench's scenarios can show the rest:
- the exact latency from the capture edge;
- the mapping of the comparator value to status, with comparator swaps late in the window;
- that held or repeated requests and a mid-window reset do not produce extra pulses.

For these, the bench sweeps all four power states against both comparator values.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

  localparam logic [1:0] PWR_P1     = 2'b10;
  localparam logic [2:0] STAT_FOUND = 3'b011;
  localparam logic [2:0] STAT_NONE  = 3'b000;

  typedef enum logic {
    ST_IDLE,
    ST_COUNT
  } detState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearCnt;     // begin a window: zero the counter
    logic stepCnt;      // advance the window counter
    logic latchResult;  // sample comparator, raise done
  } detStrobes_t;

endpackage

// File: rtl/rxdet_ctrl.sv
module rxdet_ctrl
  import rxdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        detReq,
  input  logic [1:0]  pwrState,
  input  logic        cntLast,
  output detStrobes_t strb
);

  detState_t state;
  detState_t stateNext;
  logic      reqPrev;
  logic      reqRise;

  // Held high across reset so a request stuck high cannot fire afterwards
  always_ff @(posedge clk) begin
    if (rst) reqPrev <= 1'b1;
    else     reqPrev <= detReq;
  end

  assign reqRise = detReq & ~reqPrev;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqRise && (pwrState == PWR_P1)) begin
          strb.clearCnt = 1'b1;
          stateNext     = ST_COUNT;
        end
      end
      ST_COUNT: begin
        strb.stepCnt = 1'b1;
        if (cntLast) begin
          strb.latchResult = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // R2: a window is only ever entered from a P1 request
  p_start_in_p1_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_COUNT) |-> ($past(pwrState) == PWR_P1))
    else $error("R2: window started outside P1");

  // R8: a running window is never restarted by a new request edge
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT) |-> !strb.clearCnt)
    else $error("R8: restart during window");

endmodule

// File: rtl/rxdet_datapath.sv
module rxdet_datapath
  import rxdet_pkg::*;
#(
  parameter int DETECT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  detStrobes_t strb,
  input  logic        farEndSeen,
  output logic        cntLast,
  output logic        phyDone,
  output logic [2:0]  phyStatus
);

  localparam int CW = (DETECT_CYCLES > 1) ? $clog2(DETECT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_COUNT = CW'(DETECT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (strb.clearCnt) cnt <= '0;
    else if (strb.stepCnt)  cnt <= cnt + CW'(1);
  end

  assign cntLast = (cnt == LAST_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phyDone   <= 1'b0;
      phyStatus <= STAT_NONE;
    end else begin
      phyDone   <= strb.latchResult;
      phyStatus <= (strb.latchResult && farEndSeen) ? STAT_FOUND : STAT_NONE;
    end
  end

  // R4: done never lasts two cycles
  p_done_one_wide_r4: assert property (@(posedge clk) disable iff (rst)
    phyDone |=> !phyDone)
    else $error("R4: done wider than one cycle");

  // R7: status quiet whenever done is low
  p_status_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !phyDone |-> (phyStatus == STAT_NONE))
    else $error("R7: status nonzero without done");

  // R5/R6: only the two legal codes appear with done
  p_status_legal_r5: assert property (@(posedge clk) disable iff (rst)
    phyDone |-> ((phyStatus == STAT_FOUND) || (phyStatus == STAT_NONE)))
    else $error("R5: illegal status code");

  // R3: done only follows the final count of a running window
  p_done_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(phyDone) |-> ($past(cntLast) && $past(strb.stepCnt)))
    else $error("R3: done without completed window");

endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq
  import rxdet_pkg::*;
#(
  parameter int DETECT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       detReq,
  input  logic [1:0] pwrState,
  input  logic       farEndSeen,
  output logic       phyDone,
  output logic [2:0] phyStatus
);

  detStrobes_t strb;
  logic        cntLast;

  rxdet_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .detReq   (detReq),
    .pwrState (pwrState),
    .cntLast  (cntLast),
    .strb     (strb)
  );

  rxdet_datapath #(
    .DETECT_CYCLES (DETECT_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .farEndSeen (farEndSeen),
    .cntLast    (cntLast),
    .phyDone    (phyDone),
    .phyStatus  (phyStatus)
  );

endmodule

// File: tb/sim_rxdet_seq.sv
module sim_rxdet_seq;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       detReq;
  logic [1:0] pwrState;
  logic       farEndSeen;
  logic       phyDone;
  logic [2:0] phyStatus;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdet_seq #(.DETECT_CYCLES(N)) u0 (
    .clk(clk), .rst(rst), .detReq(detReq), .pwrState(pwrState),
    .farEndSeen(farEndSeen), .phyDone(phyDone), .phyStatus(phyStatus)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkQuiet(input string tag);
    check(phyDone == 1'b0, tag, phyDone, 0);
    check(phyStatus == 3'b000, tag, phyStatus, 0);
  endtask

  // Rising request; farLate applied just before the edge that should raise done
  task automatic runDetect(input logic [1:0] pwr, input logic farEarly, input logic farLate);
    bit willStart;
    int expStat;
    willStart = (pwr == 2'b10);
    expStat = (willStart && farLate) ? 3 : 0;
    @(negedge clk);
    pwrState = pwr; farEndSeen = farEarly; detReq = 1'b1;
    for (int i = 1; i <= N + 1; i++) begin
      tick();
      if (i <= N) begin
        check(phyDone == 1'b0, "R3 early done", phyDone, 0);
        check(phyStatus == 3'b000, "R7 status before done", phyStatus, 0);
        if (i == N) farEndSeen = farLate;
      end else begin
        check(phyDone == willStart, willStart ? "R3 done latency" : "R2 non-P1 done", phyDone, willStart);
        check(int'(phyStatus) == expStat, farLate ? "R5 status found" : "R6 status none", phyStatus, expStat);
      end
    end
    tick();
    checkQuiet("R4 R7 after done");
    @(negedge clk);
    detReq = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulses;
    rst = 1'b1; detReq = 1'b0; pwrState = 2'b00; farEndSeen = 1'b0;
    repeat (3) tick();
    checkQuiet("R1 reset state");
    @(negedge clk); rst = 1'b0;
    tick();

    // Sweep: all power states against both comparator values (R2 R5 R6)
    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 2; f++)
        runDetect(2'(p), 1'(f), 1'(f));

    // R9: comparator value earlier in the window is ignored
    runDetect(2'b10, 1'b1, 1'b0);
    runDetect(2'b10, 1'b0, 1'b1);

    // R8: held request gives a single pulse
    @(negedge clk); pwrState = 2'b10; farEndSeen = 1'b1; detReq = 1'b1;
    pulses = 0;
    for (int i = 0; i < 4 * N; i++) begin tick(); if (phyDone) pulses++; end
    check(pulses == 1, "R8 held request pulses", pulses, 1);

    // R8: re-rising request during a window gives one pulse
    @(negedge clk); detReq = 1'b0; tick();
    @(negedge clk); detReq = 1'b1;
    pulses = 0;
    for (int i = 0; i < 4 * N; i++) begin
      tick();
      if (phyDone) pulses++;
      if (i == 4) detReq = 1'b0;
      if (i == 6) detReq = 1'b1;
    end
    check(pulses == 1, "R8 retrigger in window", pulses, 1);
    @(negedge clk); detReq = 1'b0; tick();

    // R1: reset mid-window, request held through and after reset
    @(negedge clk); detReq = 1'b1;
    repeat (5) tick();
    rst = 1'b1;
    tick();
    checkQuiet("R1 mid-window reset");
    @(negedge clk); rst = 1'b0;
    pulses = 0;
    for (int i = 0; i < 3 * N; i++) begin tick(); if (phyDone) pulses++; end
    check(pulses == 0, "R1 no window after reset", pulses, 0);
    @(negedge clk); detReq = 1'b0; tick();

    // Normal operation resumes afterwards
    runDetect(2'b10, 1'b1, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule